// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Fill Thresholds

A single-clock FIFO with one write port and one read port. Besides full and empty it reports a half-full level and two user-set levels: an almost-empty level driven by an empty offset `n` and an almost-full level driven by a full offset `m`. Both offsets sit in one internal register. Software can set that register in one of two ways: in parallel through the write data bus, or one bit per clock through a serial pin. It reads the register back through the read data bus.

The read side runs in one of two modes, latched while reset is held. In standard mode a read strobe moves the next word into the output register on the following edge. In first-word-fall-through mode the head word is placed on the output by itself. The output register then counts as one extra storage slot, so every fill threshold moves up by one word. A retransmit strobe sends the read side back to the first word written since reset so that the stored data can be replayed.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `rstN` is low on a clock edge, both pointers clear. `empty` and `almostEmpty` become 1 and `full`, `halfFull`, `almostFull` become 0. `rdData` becomes 0. Both offsets load the default picked by `ofsDfltSel` (0 picks `DFLT_OFS_0`, 1 picks `DFLT_OFS_1`).
- R2: Words leave in the order they were accepted. In standard mode an accepted read puts the next word on `rdData` after that edge, and `rdData` holds its value otherwise.
- R3: A write while the memory holds `DEPTH` words is dropped. In standard mode a read while `empty` is 1 is dropped and `rdData` is left unchanged.
- R4: `full` is 1 exactly when the stored word count equals `DEPTH` in standard mode, or `DEPTH+1` in fall-through mode. The output register counts toward the total in fall-through mode.
- R5: `halfFull` is 1 when the count is at least `DEPTH/2+1` in standard mode, or at least `DEPTH/2+2` in fall-through mode.
- R6: `almostFull` is 1 when the count is at least `DEPTH-m` in standard mode, or at least `DEPTH+1-m` in fall-through mode.
- R7: `almostEmpty` is 1 when the count is at most `n` in standard mode, or at most `n+1` in fall-through mode.
- R8: In fall-through mode, `empty` is 0 exactly while a valid head word is on `rdData`. A word written into an empty FIFO shows up, with `empty` low, one cycle after the write edge. A read consumes that head word.
- R9: Each edge with `serEn` high and no parallel load shifts `serBit` into the offset register. After `2*OFS_W` shifts, the first bit is the LSB of `n`, then come the higher bits of `n`, then `m` from LSB to MSB, and the last bit is the MSB of `m`.
- R10: `cfgLoad` together with `wrEn` loads `n` from `wrData[OFS_W-1:0]` and `m` from `wrData[2*OFS_W-1:OFS_W]`. It stores nothing in the FIFO.
- R11: `cfgLoad` together with `rdEn` makes `rdData` equal to `{m,n}` (zero-extended, `n` in the low bits) for the following cycle. It reads nothing from the FIFO.
- R12: `rtEn` sends the read side back to the first word written since reset and keeps the write side as it is. The flags follow the restored count. In fall-through mode that first word is on `rdData` again two edges later. Retransmit is only valid after at least two writes and two reads, and with no more than `DEPTH` writes since reset.
- R13: The mode is taken from `fwftSel` while `rstN` is low (1 = fall-through) and does not change until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| fwftSel | input | 1 | Mode select, sampled during reset |
| ofsDfltSel | input | 1 | Default offset select, sampled during reset |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data, also parallel offset data |
| rdEn | input | 1 | Read strobe |
| rdData | output | DATA_W | Read data or offset readback |
| cfgLoad | input | 1 | Redirects wrEn/rdEn to the offset register |
| serEn | input | 1 | Serial offset shift enable |
| serBit | input | 1 | Serial offset data bit |
| rtEn | input | 1 | Retransmit strobe |
| full | output | 1 | Full flag |
| empty | output | 1 | Empty flag |
| halfFull | output | 1 | Half-full flag |
| almostFull | output | 1 | Programmable almost-full flag |
| almostEmpty | output | 1 | Programmable almost-empty flag |

## Verification
The bench builds the block with `DEPTH=16` and `DATA_W=8`, which gives 4-bit offsets and an 8-bit serial sequence. At that size the FIFO can be filled past full and drained past empty in both modes within a few dozen cycles, so every threshold crossing is reached, including the half-full edges at 9 and 10 words. The two defaults, 3 and 7, differ from the parallel value 0x25 and the serial value 0x61, so a mixed-up field or a reversed bit order changes the readback value.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic memWr;    // store wrData at wrAddr
    logic outLoad;  // move mem[rdAddr] into the output register
    logic showOfs;  // present offset register on rdData next cycle
  } fifoStrb_t;

endpackage

// File: rtl/fifo_ofs_reg.sv
module fifo_ofs_reg #(
  parameter int OFS_W      = 4,
  parameter int DFLT_OFS_0 = 3,
  parameter int DFLT_OFS_1 = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dfltSel,
  input  logic               parLoad,
  input  logic [2*OFS_W-1:0] parData,
  input  logic               serEn,
  input  logic               serBit,
  output logic [OFS_W-1:0]   emptyOfs,
  output logic [OFS_W-1:0]   fullOfs
);

  localparam int REG_W = 2 * OFS_W;
  localparam logic [OFS_W-1:0] DFLT0 = OFS_W'(DFLT_OFS_0);
  localparam logic [OFS_W-1:0] DFLT1 = OFS_W'(DFLT_OFS_1);

  // {full offset, empty offset}: serial bits enter at the top and move down,
  // so the first bit of a full sequence ends up in bit 0.
  logic [REG_W-1:0] ofsQ;
  logic [OFS_W-1:0] dfltVal;

  assign dfltVal = dfltSel ? DFLT1 : DFLT0;

  always_ff @(posedge clk) begin
    if (!rstN)        ofsQ <= {dfltVal, dfltVal};
    else if (parLoad) ofsQ <= parData;
    else if (serEn)   ofsQ <= {serBit, ofsQ[REG_W-1:1]};
  end

  assign emptyOfs = ofsQ[OFS_W-1:0];
  assign fullOfs  = ofsQ[REG_W-1:OFS_W];

  // R10: a parallel load lands verbatim
  p_par_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    parLoad |=> ofsQ == $past(parData));

  // R9: without a load or shift the offsets are kept
  p_ofs_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!parLoad && !serEn) |=> $stable(ofsQ));

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_ofs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fwftSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              cfgLoad,
  input  logic              rtEn,
  input  logic [OFS_W-1:0]  emptyOfs,
  input  logic [OFS_W-1:0]  fullOfs,
  output fifoStrb_t         strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              parLoad,
  output logic              full,
  output logic              empty,
  output logic              halfFull,
  output logic              almostFull,
  output logic              almostEmpty
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int CNT_W = ADDR_W + 2;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(DEPTH / 2 + 1);

  logic             fwftQ;
  logic             outValidQ;
  logic [PTR_W-1:0] wrPtrQ, rdPtrQ;
  logic [PTR_W-1:0] memCnt;
  logic [CNT_W-1:0] tot, shift;
  logic             memHasData, memFull;
  logic             wrAcc, rdReq, consume, outLoad;

  assign memCnt     = wrPtrQ - rdPtrQ;
  assign memHasData = (memCnt != '0);
  assign memFull    = (memCnt == DEPTH_P);

  assign wrAcc   = wrEn & ~cfgLoad & ~memFull;
  assign rdReq   = rdEn & ~cfgLoad & ~rtEn;
  assign consume = fwftQ & rdReq & outValidQ;
  // Standard: load on request. Fall-through: refill whenever the slot is free.
  assign outLoad = ~rtEn & memHasData & (fwftQ ? (~outValidQ | consume) : rdReq);
  assign parLoad = cfgLoad & wrEn;

  assign strb.memWr   = wrAcc;
  assign strb.outLoad = outLoad;
  assign strb.showOfs = cfgLoad & rdEn;

  assign wrAddr = wrPtrQ[ADDR_W-1:0];
  assign rdAddr = rdPtrQ[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwftQ     <= fwftSel;
      wrPtrQ    <= '0;
      rdPtrQ    <= '0;
      outValidQ <= 1'b0;
    end else begin
      if (wrAcc) wrPtrQ <= wrPtrQ + 1'b1;
      if (rtEn)         rdPtrQ <= '0;
      else if (outLoad) rdPtrQ <= rdPtrQ + 1'b1;
      if (rtEn || !fwftQ) outValidQ <= 1'b0;
      else if (outLoad)   outValidQ <= 1'b1;
      else if (consume)   outValidQ <= 1'b0;
    end
  end

  // Flags from registered state; fall-through adds the output slot and
  // moves each threshold up by one.
  assign shift = {{(CNT_W-1){1'b0}}, fwftQ};
  assign tot   = CNT_W'(memCnt) + CNT_W'(outValidQ);

  assign full        = (tot == DEPTH_C + shift);
  assign empty       = fwftQ ? ~outValidQ : ~memHasData;
  assign halfFull    = (tot >= HALF_C + shift);
  assign almostFull  = (tot >= DEPTH_C + shift - CNT_W'(fullOfs));
  assign almostEmpty = (tot <= CNT_W'(emptyOfs) + shift);

  // R3: no write advances past a full FIFO
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    full |=> wrPtrQ == $past(wrPtrQ));

  // R3: no standard-mode read from an empty FIFO
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!fwftQ && empty && !rtEn) |=> rdPtrQ == $past(rdPtrQ));

  // R4: full and empty never coincide
  p_full_empty_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  // R12: retransmit rewinds the read side
  p_rt_rewind_r12: assert property (@(posedge clk) disable iff (!rstN)
    rtEn |=> rdPtrQ == '0);

  // R13: mode fixed outside reset
  p_mode_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(fwftQ));

endmodule

// File: rtl/fifo_dpath.sv
module fifo_dpath
  import fifo_ofs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  parameter int OFS_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifoStrb_t          strb,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [2*OFS_W-1:0] ofsBits,
  output logic [DATA_W-1:0]  rdData
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] outQ;
  logic              showQ;

  always_ff @(posedge clk) begin
    if (strb.memWr) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ  <= '0;
      showQ <= 1'b0;
    end else begin
      if (strb.outLoad) outQ <= mem[rdAddr];
      showQ <= strb.showOfs;
    end
  end

  assign rdData = showQ ? DATA_W'(ofsBits) : outQ;

endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import fifo_ofs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 16,
  parameter int DFLT_OFS_0 = 3,
  parameter int DFLT_OFS_1 = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fwftSel,
  input  logic              ofsDfltSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              cfgLoad,
  input  logic              serEn,
  input  logic              serBit,
  input  logic              rtEn,
  output logic              full,
  output logic              empty,
  output logic              halfFull,
  output logic              almostFull,
  output logic              almostEmpty
);

  // DEPTH is a power of two; DATA_W must hold both offsets side by side.
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int OFS_W  = ADDR_W;

  fifoStrb_t         strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              parLoad;
  logic [OFS_W-1:0]  emptyOfs, fullOfs;

  fifo_ofs_reg #(
    .OFS_W(OFS_W), .DFLT_OFS_0(DFLT_OFS_0), .DFLT_OFS_1(DFLT_OFS_1)
  ) uOfs (
    .clk(clk), .rstN(rstN), .dfltSel(ofsDfltSel),
    .parLoad(parLoad), .parData(wrData[2*OFS_W-1:0]),
    .serEn(serEn), .serBit(serBit),
    .emptyOfs(emptyOfs), .fullOfs(fullOfs)
  );

  fifo_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .fwftSel(fwftSel),
    .wrEn(wrEn), .rdEn(rdEn), .cfgLoad(cfgLoad), .rtEn(rtEn),
    .emptyOfs(emptyOfs), .fullOfs(fullOfs),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr), .parLoad(parLoad),
    .full(full), .empty(empty), .halfFull(halfFull),
    .almostFull(almostFull), .almostEmpty(almostEmpty)
  );

  fifo_dpath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .ofsBits({fullOfs, emptyOfs}), .rdData(rdData)
  );

endmodule

// File: tb/sim_prog_flag_fifo.sv
`timescale 1ns/1ps
module sim_prog_flag_fifo;

  localparam int D   = 16;
  localparam int W   = 8;
  localparam int DF0 = 3;
  localparam int DF1 = 7;

  logic clk = 1'b0;
  logic rstN, fwftSel, ofsDfltSel, wrEn, rdEn, cfgLoad, serEn, serBit, rtEn;
  logic [W-1:0] wrData, rdData;
  logic full, empty, halfFull, almostFull, almostEmpty;

  always #2.5 clk = ~clk;

  prog_flag_fifo #(.DATA_W(W), .DEPTH(D), .DFLT_OFS_0(DF0), .DFLT_OFS_1(DF1)) u0 (
    .clk(clk), .rstN(rstN), .fwftSel(fwftSel), .ofsDfltSel(ofsDfltSel),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .cfgLoad(cfgLoad), .serEn(serEn), .serBit(serBit), .rtEn(rtEn),
    .full(full), .empty(empty), .halfFull(halfFull),
    .almostFull(almostFull), .almostEmpty(almostEmpty)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Behavioural reference: every accepted word since reset, and a read index
  int  wq[$];
  int  rdIdx;
  bit  mFwft, mOv, mShow;
  int  mOut, mOfs;

  task automatic chkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    int memCnt;
    bit cons;
    if (!rstN) begin
      wq.delete(); rdIdx = 0; mOv = 0; mOut = 0; mShow = 0;
      mFwft = fwftSel;
      mOfs  = ofsDfltSel ? (DF1 << 4) | DF1 : (DF0 << 4) | DF0;
      return;
    end
    memCnt = wq.size() - rdIdx;
    if (rtEn) begin
      rdIdx = 0; mOv = 0;
    end else if (!mFwft) begin
      if (rdEn && !cfgLoad && memCnt > 0) begin mOut = wq[rdIdx]; rdIdx++; end
    end else begin
      cons = rdEn && !cfgLoad && mOv;
      if (memCnt > 0 && (!mOv || cons)) begin mOut = wq[rdIdx]; rdIdx++; mOv = 1; end
      else if (cons) mOv = 0;
    end
    if (wrEn && !cfgLoad && memCnt < D) wq.push_back(int'(wrData));
    if (cfgLoad && wrEn) mOfs = int'(wrData);
    else if (serEn) mOfs = (mOfs >> 1) | (int'(serBit) << 7);
    mShow = cfgLoad && rdEn;
  endtask

  task automatic compareAll();
    int tot, s, n, m;
    s   = mFwft ? 1 : 0;
    tot = wq.size() - rdIdx + (mFwft && mOv ? 1 : 0);
    n   = mOfs & 15;
    m   = mOfs >> 4;
    chkEq("R4 full",        full,        tot == D + s);
    chkEq("R8 empty",       empty,       mFwft ? !mOv : tot == 0);
    chkEq("R5 halfFull",    halfFull,    tot >= D / 2 + 1 + s);
    chkEq("R6 almostFull",  almostFull,  tot >= D + s - m);
    chkEq("R7 almostEmpty", almostEmpty, tot <= n + s);
    if (mShow)       chkEq("R11 readback", rdData, mOfs);
    else if (!mFwft) chkEq("R2 rdData",    rdData, mOut);
    else if (mOv)    chkEq("R2 head word", rdData, mOut);
  endtask

  task automatic cyc();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    wrEn = 0; rdEn = 0; cfgLoad = 0; serEn = 0; serBit = 0; rtEn = 0;
  endtask

  task automatic doReset(input bit fw, input bit ds);
    idle(); rstN = 0; fwftSel = fw; ofsDfltSel = ds;
    cyc(); cyc();
    rstN = 1; fwftSel = ~fw;   // later changes must be ignored (R13)
  endtask

  task automatic writeWord(input int v);
    idle(); wrEn = 1; wrData = W'(v); cyc(); idle();
  endtask

  task automatic readWord();
    idle(); rdEn = 1; cyc(); idle();
  endtask

  task automatic readBack();
    idle(); cfgLoad = 1; rdEn = 1; cyc(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=0 (all requirements)", 200000);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    bit sbits[8];
    wrData = '0;
    idle();
    // ---------------- standard mode, default 0 ----------------
    doReset(1'b0, 1'b0);
    chkEq("R1 empty", empty, 1); chkEq("R1 full", full, 0);
    chkEq("R1 almostEmpty", almostEmpty, 1); chkEq("R1 halfFull", halfFull, 0);
    chkEq("R1 almostFull", almostFull, 0); chkEq("R1 rdData", rdData, 0);
    readBack();
    chkEq("R1 default offsets", rdData, 8'h33);
    cyc();
    writeWord(8'h55);
    chkEq("R13 standard: no fall-through", rdData, 0);
    chkEq("R13 not empty", empty, 0);
    readWord();
    chkEq("R2 first word", rdData, 8'h55);
    // fill past full
    for (int i = 0; i < D + 1; i++) writeWord(8'h10 + i);
    chkEq("R3 full after overflow attempt", full, 1);
    for (int i = 0; i < D + 1; i++) readWord();
    chkEq("R3 last real word kept", rdData, 8'h1F);
    chkEq("R3 empty", empty, 1);
    // parallel load n=5, m=2
    idle(); cfgLoad = 1; wrEn = 1; wrData = 8'h25; cyc(); idle();
    chkEq("R10 no FIFO write", empty, 1);
    readBack();
    chkEq("R10 parallel offsets", rdData, 8'h25);
    for (int i = 0; i < D; i++) writeWord(8'h40 + i);
    for (int i = 0; i < D; i++) readWord();
    // serial load n=1, m=6: n LSB first ... m MSB last
    sbits = '{1, 0, 0, 0, 0, 1, 1, 0};
    foreach (sbits[k]) begin idle(); serEn = 1; serBit = sbits[k]; cyc(); end
    idle();
    readBack();
    chkEq("R9 serial offsets", rdData, 8'h61);
    chkEq("R11 no FIFO read", empty, 1);
    for (int i = 0; i < D; i++) writeWord(8'h60 + i);
    for (int i = 0; i < D; i++) readWord();
    // retransmit, standard
    doReset(1'b0, 1'b1);
    readBack();
    chkEq("R1 default offsets sel1", rdData, 8'h77);
    for (int i = 0; i < 5; i++) writeWord(8'hA0 + i);
    for (int i = 0; i < 3; i++) readWord();
    chkEq("R2 third word", rdData, 8'hA2);
    idle(); rtEn = 1; cyc(); idle();
    chkEq("R12 rdData kept", rdData, 8'hA2);
    readWord();
    chkEq("R12 replay first word", rdData, 8'hA0);
    for (int cy = 0; cy < 1500; cy++) begin
      idle();
      wrEn = ($urandom % 2) == 0; wrData = W'($urandom);
      rdEn = ($urandom % 2) == 0;
      if (($urandom % 20) == 0) begin cfgLoad = 1; wrEn = 0; rdEn = 1; end
      cyc();
    end
    // ---------------- fall-through mode ----------------
    doReset(1'b1, 1'b1);
    writeWord(8'hC3);
    chkEq("R8 empty one cycle after write", empty, 1);
    cyc();
    chkEq("R13 fall-through head", rdData, 8'hC3);
    chkEq("R8 empty low", empty, 0);
    readWord();
    for (int i = 0; i < D + 3; i++) writeWord(8'h80 + i);
    chkEq("R4 holds DEPTH+1", full, 1);
    for (int i = 0; i < D + 3; i++) readWord();
    chkEq("R3 drained", empty, 1);
    doReset(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) writeWord(8'hB0 + i);
    cyc();
    readWord(); readWord();
    chkEq("R2 head after two reads", rdData, 8'hB2);
    idle(); rtEn = 1; cyc(); idle();
    chkEq("R12 slot cleared", empty, 1);
    cyc();
    chkEq("R12 replay head", rdData, 8'hB0);
    for (int cy = 0; cy < 1500; cy++) begin
      idle();
      wrEn = ($urandom % 3) != 0; wrData = W'($urandom);
      rdEn = ($urandom % 2) == 0;
      if (($urandom % 25) == 0) begin cfgLoad = 1; wrEn = 0; rdEn = 1; end
      if (($urandom % 40) == 0) begin serEn = 1; serBit = $urandom % 2; end
      cyc();
    end
    idle();
    cyc();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule